// File: doc/BRIEF.md
# Single-Wire Bus Slot Master

This block drives an open-drain, single-wire bus with one pull-low line and samples the bus level on one input. It builds every bus slot from a 1 µs tick, which a prescaler derives from the system clock. Three commands are available: a bus reset that detects whether a device answers, an eight-bit write, and an eight-bit read.

A command is issued by raising `cmd_start` for one cycle with `cmd_kind` and `cmd_wdata` valid. The block then sequences the slots without further help. While it works, `busy` stays high. It pulses `done` when the last slot has ended and leaves the result on `rd_byte` or `presence`. Byte sequencing, CRC checking and the pull-up resistor are handled outside the block.

Every slot is a frame of fixed length. A frame has one point where the line is released and one point where the line is sampled. Between the bits of a command, only the release point changes.

Top module: `sw_slot_master`

## Requirements
- R1: After reset, `busy`, `done`, `bus_pull`, `presence` and `rd_byte` are all 0.
- R2: One tick lasts CLK_PER_TICK clock cycles. Every slot length, release point and sample point is counted in ticks from the first cycle after the command is accepted.
- R3: A reset command (`cmd_kind`=0) is one frame of 1000 ticks. `bus_pull` is high for ticks 0 to 479 and low for the rest of the frame.
- R4: In a reset frame, the synchronised bus level is sampled at tick 560. At the end of the command, `presence` is 1 if that sample was low and 0 if it was high.
- R5: A write command (`cmd_kind`=1) sends eight slots of 100 ticks each, starting with bit 0 of `cmd_wdata`. A 1 bit pulls the line for 1 tick, and a 0 bit pulls it for 89 ticks.
- R6: A read command (`cmd_kind`=2) runs eight slots of 80 ticks each. Each slot pulls the line for 1 tick and samples it at tick 8. A high sample is a 1. The first slot fills `rd_byte` bit 0 and the last slot fills bit 7.
- R7: `busy` rises in the cycle after an accepted start. It falls in the cycle after the last cycle of the final slot, and `done` is high in that same single cycle.
- R8: A `cmd_start` that arrives while `busy` is high has no effect on timing, line drive or results.
- R9: `cmd_kind`=3 is not a command. A start that carries it leaves `busy` and `bus_pull` low.
- R10: The line is never pulled at a sample point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | One-cycle command request |
| cmd_kind | input | 2 | 0 reset, 1 write, 2 read, 3 none |
| cmd_wdata | input | 8 | Byte to write, LSB first |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| rd_byte | output | 8 | Byte assembled by the last read |
| presence | output | 1 | A device answered the last reset |
| bus_pull | output | 1 | Enable of the open-drain pull-low driver |
| bus_in | input | 1 | Sensed bus level |

## Verification
The assertions check four things on every cycle:
- the line is pulled only during a command and never at a sample point;
- the `done` pulse is one cycle wide and ends `busy`;
- the tick index stays inside its frame;
- the latched command does not change while a start is refused.

The exact release tick of every bit, the sample tick, the LSB-first order and the presence and read results depend on a device answering on the line. Only the bench's scenarios can show those: its behavioural device and cycle model compare `busy`, `done` and `bus_pull` on every clock.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef enum logic [1:0] {
    K_RESET = 2'd0,
    K_WRITE = 2'd1,
    K_READ  = 2'd2,
    K_NONE  = 2'd3
  } sw_kind_e;

  localparam int unsigned RST_FRAME  = 1000;
  localparam int unsigned RST_LOW    = 480;
  localparam int unsigned RST_SAMPLE = 560;
  localparam int unsigned WR_FRAME   = 100;
  localparam int unsigned WR_LOW_ONE = 1;
  localparam int unsigned WR_LOW_ZRO = 89;
  localparam int unsigned RD_FRAME   = 80;
  localparam int unsigned RD_LOW     = 1;
  localparam int unsigned RD_SAMPLE  = 8;
  localparam int unsigned TICK_W     = $clog2(RST_FRAME + 1);

  typedef logic [TICK_W-1:0] tick_t;

  function automatic tick_t frame_ticks(sw_kind_e k);
    case (k)
      K_RESET: return tick_t'(RST_FRAME);
      K_WRITE: return tick_t'(WR_FRAME);
      default: return tick_t'(RD_FRAME);
    endcase
  endfunction

  function automatic tick_t low_ticks(sw_kind_e k, logic bitv);
    case (k)
      K_RESET: return tick_t'(RST_LOW);
      K_WRITE: return bitv ? tick_t'(WR_LOW_ONE) : tick_t'(WR_LOW_ZRO);
      default: return tick_t'(RD_LOW);
    endcase
  endfunction

  function automatic tick_t sample_tick(sw_kind_e k);
    return (k == K_RESET) ? tick_t'(RST_SAMPLE) : tick_t'(RD_SAMPLE);
  endfunction

  function automatic logic takes_sample(sw_kind_e k);
    return (k == K_RESET) || (k == K_READ);
  endfunction

  function automatic logic last_slot(sw_kind_e k, logic [2:0] idx);
    return (k == K_RESET) || (idx == 3'd7);
  endfunction
endpackage

// File: rtl/sw_tick_gen.sv
module sw_tick_gen #(
  parameter int unsigned CLK_PER_TICK = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick_first,
  output logic tick_last
);
  localparam int unsigned CW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam logic [CW-1:0] TOP = CW'(CLK_PER_TICK - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt == TOP)  cnt <= '0;
    else                  cnt <= cnt + CW'(1);
  end

  assign tick_first = run && (cnt == '0);
  assign tick_last  = run && (cnt == TOP);

  AST_TICK_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TOP); // R2
endmodule

// File: rtl/sw_sync.sv
module sw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/sw_slot_engine.sv
module sw_slot_engine
  import sw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  logic  tick_first,
  input  logic  tick_last,
  input  tick_t frame_len,
  input  tick_t low_len,
  input  tick_t sample_at,
  input  logic  sample_en,
  output logic  pull,
  output logic  slot_end,
  output logic  sample_ev
);
  tick_t tick_idx;

  assign slot_end  = run && tick_last && (tick_idx == frame_len - tick_t'(1));
  assign sample_ev = run && sample_en && tick_first && (tick_idx == sample_at);
  assign pull      = run && (tick_idx < low_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 tick_idx <= '0;
    else if (!run || slot_end)  tick_idx <= '0;
    else if (tick_last)         tick_idx <= tick_idx + tick_t'(1);
  end

  AST_TICK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> tick_idx < frame_len); // R2
  AST_RELEASED_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_ev |-> !pull); // R10
endmodule

// File: rtl/sw_slot_master.sv
module sw_slot_master
  import sw_pkg::*;
#(
  parameter int unsigned CLK_PER_TICK = 4,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_start,
  input  logic [1:0] cmd_kind,
  input  logic [7:0] cmd_wdata,
  output logic       busy,
  output logic       done,
  output logic [7:0] rd_byte,
  output logic       presence,
  output logic       bus_pull,
  input  logic       bus_in
);
  sw_kind_e   kind_q;
  logic [7:0] data_q;
  logic [2:0] bit_idx;
  logic       accept;
  logic       tick_first, tick_last;
  logic       line_s;
  logic       eng_pull, slot_end, sample_ev;

  assign accept = cmd_start && !busy && (sw_kind_e'(cmd_kind) != K_NONE);

  sw_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .tick_first(tick_first), .tick_last(tick_last)
  );

  sw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(bus_in), .dout(line_s)
  );

  sw_slot_engine u_eng (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .tick_first(tick_first), .tick_last(tick_last),
    .frame_len(frame_ticks(kind_q)),
    .low_len(low_ticks(kind_q, data_q[bit_idx])),
    .sample_at(sample_tick(kind_q)),
    .sample_en(takes_sample(kind_q)),
    .pull(eng_pull), .slot_end(slot_end), .sample_ev(sample_ev)
  );

  assign bus_pull = eng_pull;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      kind_q  <= K_RESET;
      data_q  <= '0;
      bit_idx <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        kind_q  <= sw_kind_e'(cmd_kind);
        data_q  <= cmd_wdata;
        bit_idx <= '0;
      end else if (slot_end) begin
        if (last_slot(kind_q, bit_idx)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          bit_idx <= bit_idx + 3'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_byte  <= '0;
      presence <= 1'b0;
    end else if (sample_ev) begin
      if (kind_q == K_READ) rd_byte  <= {line_s, rd_byte[7:1]};
      else                  presence <= !line_s;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_PULL_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_pull |-> busy); // R9
  AST_REFUSED_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !slot_end) |=> $stable(kind_q) && $stable(data_q)); // R8
endmodule

// File: tb/sw_slot_master_bench.sv
module sw_slot_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P = 4;

  logic clk = 0, rst_n = 0;
  logic cmd_start = 0;
  logic [1:0] cmd_kind = 0;
  logic [7:0] cmd_wdata = 0;
  logic busy, done, presence, bus_pull, bus_in;
  logic [7:0] rd_byte;

  int checks = 0, errs = 0;
  bit dev_present = 1;
  logic [7:0] dev_byte = 8'h00;

  // behavioural model state
  bit m_busy = 0, m_done = 0;
  int m_cyc = 0, m_total = 0, m_kind = 0;
  logic [7:0] m_data = 0;
  bit exp_pull, dev_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_slot_master #(.CLK_PER_TICK(P)) u_sw_slot_master (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_kind(cmd_kind),
    .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .rd_byte(rd_byte),
    .presence(presence), .bus_pull(bus_pull), .bus_in(bus_in)
  );

  function automatic int slot_cyc(int k);
    return (k == 0 ? 1000 : (k == 1 ? 100 : 80)) * P;
  endfunction
  function automatic int n_slots(int k);
    return (k == 0) ? 1 : 8;
  endfunction

  always @* begin
    int sl, idx, tin, low;
    exp_pull = 0; dev_low = 0;
    if (m_busy) begin
      sl = slot_cyc(m_kind); idx = m_cyc / sl; tin = m_cyc % sl;
      if (m_kind == 0) low = 480;
      else if (m_kind == 2) low = 1;
      else low = m_data[idx] ? 1 : 89;
      exp_pull = (tin < low * P);
      if (m_kind == 0) dev_low = dev_present && tin >= 500*P && tin < 700*P;
      if (m_kind == 2) dev_low = !dev_byte[idx] && tin >= P && tin < 30*P;
    end
  end

  assign bus_in = !(bus_pull || dev_low);

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_cyc <= 0;
    end else if (m_busy && m_cyc == m_total - 1) begin
      m_busy <= 0; m_done <= 1;
    end else begin
      m_done <= 0;
      if (m_busy) m_cyc <= m_cyc + 1;
      else if (cmd_start && cmd_kind != 2'd3) begin
        m_busy <= 1; m_cyc <= 0; m_kind <= int'(cmd_kind); m_data <= cmd_wdata;
        m_total <= n_slots(int'(cmd_kind)) * slot_cyc(int'(cmd_kind));
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk(busy == m_busy, "R7 busy", busy, m_busy);
    chk(done == m_done, "R7 done", done, m_done);
    // line drive timing: R3 reset, R5 write, R6 read, scaled per R2; R10 released at sample
    chk(bus_pull == exp_pull, "R3/R5/R6 bus_pull", bus_pull, exp_pull);
    if (m_done && m_kind == 2) chk(rd_byte == dev_byte, "R6 rd_byte", rd_byte, dev_byte);
    if (m_done && m_kind == 0) chk(presence == dev_present, "R4 presence", presence, dev_present);
  end

  task automatic issue(int k, logic [7:0] d);
    @(negedge clk); cmd_start = 1; cmd_kind = 2'(k); cmd_wdata = d;
    @(negedge clk); cmd_start = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] keep;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && bus_pull == 0, "R1 idle outputs", {busy, done, bus_pull}, 0);
    chk(rd_byte == 0, "R1 rd_byte", rd_byte, 0);
    chk(presence == 0, "R1 presence", presence, 0);

    dev_present = 1; issue(0, 8'h00); wait_done();
    dev_present = 0; issue(0, 8'h00); wait_done();
    issue(1, 8'hA5); wait_done();
    issue(1, 8'h00); wait_done();
    dev_byte = 8'h3C; issue(2, 8'h00); wait_done();
    dev_byte = 8'hFF; issue(2, 8'h00); wait_done();

    // R9 kind 3 is not a command
    issue(3, 8'h55);
    repeat (3) @(negedge clk);
    chk(busy == 0 && bus_pull == 0, "R9 kind3 ignored", {busy, bus_pull}, 0);

    // R8 start during busy ignored: write in progress, a read request must not take over
    keep = rd_byte;
    dev_byte = 8'h00;
    issue(1, 8'h81);
    repeat (50) @(negedge clk);
    cmd_start = 1; cmd_kind = 2'd2;
    @(negedge clk); cmd_start = 0;
    wait_done();
    repeat (5) @(negedge clk);
    chk(busy == 0, "R8 no queued command", busy, 0);
    chk(rd_byte == keep, "R8 rd_byte untouched", rd_byte, keep);

    dev_byte = 8'h96; issue(2, 8'h00); wait_done();
    dev_present = 1; issue(0, 8'h00); wait_done();

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule